// File: doc/BRIEF.md
# Register-Programmed Byte Copy Engine

This block is a single-channel copy engine. Software sets a source address, a destination address and a byte count in three 64-bit registers, then writes a command word to start the copy. One end of the copy is always a 4096-byte buffer inside the block, and the other end is always an external byte-wide memory reached through a request/acknowledge port. The buffer sits in the device address window from 0x40000 to 0x40FFF. The device-side address is turned into a buffer index by subtracting 0x40000. The host-side address is reduced to a parameter number of low bits, 28 by default.

The start bit of the command word is also the busy flag. It reads back as 1 while bytes remain to be moved and drops to 0 on completion, so a driver can start a copy and then poll the same register. When the command asked for it, the engine puts the value 0x100 on a one-cycle interrupt-status output at completion.

Registers are addressed by a 32-bit word index `reg_word`, which is byte offset bits 7:2. A wide access moves 64 bits. A narrow access moves the 32-bit half that `reg_word[0]` selects: 0 is the low half and 1 is the high half. Narrow data always sits in the low 32 bits of the data buses.

Top module: `dma_copy_engine`

## Requirements
- R1: After reset, the command register reads 0 (start bit 0), `mem_req` is 0 and `irq_set` is 0.
- R2: The registers sit at byte offsets source 0x80, destination 0x88, count 0x90 and command 0x98. A wide write replaces all 64 bits. A narrow write to byte offset +4 replaces only the upper 32 bits. A narrow read returns the selected half, zero-extended.
- R3: Writing a command with bit 0 (value 0x01) set while idle starts a copy. Command bit 0 reads 1 in the cycle after that write and stays 1 until the copy completes, then reads 0.
- R4: With command bit 1 (value 0x02) clear, bytes read from external memory at addresses source, source+1, … are stored into the buffer at indices destination−0x40000, +1, ….
- R5: With command bit 1 set, the buffer bytes at indices source−0x40000, +1, … are written to external memory at destination, destination+1, ….
- R6: The external address is the host-side register plus the byte number, reduced to its low HAW bits (default 28). It wraps inside that width.
- R7: The number of bytes moved is the smaller of the count and the room left from the buffer index to byte 4095. A device address outside 0x40000–0x40FFF moves no bytes.
- R8: When command bit 2 (value 0x04) was set at start, `irq_set` equals 0x100 for exactly one cycle at completion. Otherwise it stays 0.
- R9: While bit 0 reads 1, writes to the source, destination, count and command registers are ignored.
- R10: A count of zero raises no memory request. Bit 0 reads 1 for exactly one cycle and then 0, and the 0x100 pulse still occurs when bit 2 is set.
- R11: Each byte takes one handshake: `mem_req` stays high with a stable address until a cycle with `mem_ack` high, and the number of handshakes equals the byte count from R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_word | input | 6 | Register word index (byte offset bits 7:2) |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| buf_we | input | 1 | Host write strobe into the buffer (ignored while busy) |
| buf_addr | input | 12 | Host buffer byte index |
| buf_wdata | input | 8 | Host buffer write byte |
| buf_rdata | output | 8 | Buffer byte at `buf_addr` (combinational) |
| mem_req | output | 1 | External memory request |
| mem_we | output | 1 | 1 = write to external memory, 0 = read |
| mem_addr | output | 28 | External byte address |
| mem_wdata | output | 8 | Byte to write to external memory |
| mem_ack | input | 1 | Handshake complete this cycle |
| mem_rdata | input | 8 | Byte returned with `mem_ack` on reads |
| irq_set | output | 32 | Interrupt status bits to raise, one cycle |

## Verification
Copies are run in both directions with a memory model that acknowledges after random delays. This separates a correct one-byte-per-handshake flow from one that advances without an acknowledge. Directed copies are placed against the buffer's upper edge, below and above the window, with a zero count, and with host addresses that carry high bits and wrap at 2^28. These tell clamping, window decoding and masking apart from plain incrementing. A long copy is interrupted by register writes to show that programming is frozen while busy. Random copies with mixed directions, offsets, counts and interrupt requests are then compared byte by byte against a shadow copy of the buffer kept by the bench.

// File: rtl/dma_copy_engine.sv
module dma_copy_engine #(
  parameter int          HAW       = 28,
  parameter int          BUF_BYTES = 4096,
  parameter logic [63:0] WIN_BASE  = 64'h40000,
  parameter logic [31:0] IRQ_CODE  = 32'h100
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_we,
  input  logic [5:0]                   reg_word,
  input  logic                         reg_wide,
  input  logic [63:0]                  reg_wdata,
  output logic [63:0]                  reg_rdata,
  input  logic                         buf_we,
  input  logic [$clog2(BUF_BYTES)-1:0] buf_addr,
  input  logic [7:0]                   buf_wdata,
  output logic [7:0]                   buf_rdata,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [HAW-1:0]               mem_addr,
  output logic [7:0]                   mem_wdata,
  input  logic                         mem_ack,
  input  logic [7:0]                   mem_rdata,
  output logic [31:0]                  irq_set
);
  localparam int BIW = $clog2(BUF_BYTES);
  localparam logic [4:0] Q_SRC = 5'h10, Q_DST = 5'h11, Q_CNT = 5'h12, Q_CMD = 5'h13;

  logic [63:0] src_q, dst_q, cnt_q;
  logic dir_q, irqen_q, busy, irq_q;
  logic [BIW:0] left;
  logic [BIW-1:0] bidx;
  logic [HAW-1:0] hptr;
  logic [7:0] bufm [BUF_BYTES];

  function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] wd,
                                        input logic wide, input logic hi);
    if (wide) return wd;
    if (hi) return {wd[31:0], old[31:0]};
    return {old[63:32], wd[31:0]};
  endfunction

  wire hi      = reg_word[0];
  wire wr_prog = reg_we && !busy;
  wire wr_src  = wr_prog && reg_word[5:1] == Q_SRC;
  wire wr_dst  = wr_prog && reg_word[5:1] == Q_DST;
  wire wr_cnt  = wr_prog && reg_word[5:1] == Q_CNT;
  wire wr_cmd  = wr_prog && reg_word[5:1] == Q_CMD && !hi;
  wire go      = wr_cmd && reg_wdata[0];
  wire step    = mem_req && mem_ack;

  logic [63:0] dev_a, off_a, room_a;
  logic [BIW:0] eff;
  logic inwin;

  always_comb begin
    dev_a  = reg_wdata[1] ? src_q : dst_q;
    off_a  = dev_a - WIN_BASE;
    room_a = 64'(BUF_BYTES) - off_a;
    inwin  = (dev_a >= WIN_BASE) && (off_a < 64'(BUF_BYTES));
    if (!inwin)             eff = '0;
    else if (cnt_q < room_a) eff = cnt_q[BIW:0];
    else                    eff = room_a[BIW:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
      irqen_q <= 1'b0;
      busy    <= 1'b0;
      irq_q   <= 1'b0;
      left    <= '0;
      bidx    <= '0;
      hptr    <= '0;
    end else begin
      irq_q <= 1'b0;
      if (wr_src) src_q <= merge(src_q, reg_wdata, reg_wide, hi);
      if (wr_dst) dst_q <= merge(dst_q, reg_wdata, reg_wide, hi);
      if (wr_cnt) cnt_q <= merge(cnt_q, reg_wdata, reg_wide, hi);
      if (wr_cmd) begin
        dir_q   <= reg_wdata[1];
        irqen_q <= reg_wdata[2];
      end
      if (go) begin
        busy <= 1'b1;
        left <= eff;
        bidx <= off_a[BIW-1:0];
        hptr <= reg_wdata[1] ? dst_q[HAW-1:0] : src_q[HAW-1:0];
      end else if (busy) begin
        if (left == '0) begin
          busy  <= 1'b0;
          irq_q <= irqen_q;
        end else if (step) begin
          left <= left - (BIW+1)'(1);
          bidx <= bidx + BIW'(1);
          hptr <= hptr + HAW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (step && !dir_q) bufm[bidx] <= mem_rdata;
    else if (buf_we && !busy) bufm[buf_addr] <= buf_wdata;
  end

  logic [63:0] rsel;
  always_comb begin
    case (reg_word[5:1])
      Q_SRC:   rsel = src_q;
      Q_DST:   rsel = dst_q;
      Q_CNT:   rsel = cnt_q;
      Q_CMD:   rsel = {61'b0, irqen_q, dir_q, busy};
      default: rsel = '0;
    endcase
  end

  assign reg_rdata = reg_wide ? rsel : {32'b0, hi ? rsel[63:32] : rsel[31:0]};
  assign buf_rdata = bufm[buf_addr];
  assign mem_req   = busy && left != '0;
  assign mem_we    = dir_q;
  assign mem_addr  = hptr;
  assign mem_wdata = bufm[bidx];
  assign irq_set   = irq_q ? IRQ_CODE : 32'b0;
endmodule

// File: rtl/dma_copy_engine_chk.sv
module dma_copy_engine_chk #(
  parameter int HAW = 28,
  parameter int BIW = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           dir_q,
  input logic [BIW:0]   left,
  input logic           mem_req,
  input logic           mem_ack,
  input logic           mem_we,
  input logic [HAW-1:0] mem_addr,
  input logic [31:0]    irq_set
);
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !busy && !mem_req && irq_set == 32'b0);

  p_req_only_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  p_irq_at_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set != 32'b0 |-> irq_set == 32'h100 && $fell(busy));

  p_dir_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(dir_q));

  p_zero_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && left == '0 |=> !busy);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
endmodule

bind dma_copy_engine dma_copy_engine_chk #(.HAW(HAW), .BIW(BIW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .dir_q(dir_q), .left(left),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we), .mem_addr(mem_addr),
  .irq_set(irq_set)
);

// File: tb/sim_dma_copy_engine.sv
`timescale 1ns/1ps
module sim_dma_copy_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, reg_wide = 1'b1;
  logic [5:0] reg_word = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic buf_we = 1'b0;
  logic [11:0] buf_addr = '0;
  logic [7:0] buf_wdata = '0, buf_rdata;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [27:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = '0;
  logic [31:0] irq_set;

  dma_copy_engine u0 (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int hs = 0, wn = 0, irq_n = 0;
  logic [31:0] irq_last;
  logic [27:0] wlog_a [4096];
  logic [7:0]  wlog_d [4096];
  logic [7:0]  shadow [4096];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [7:0] hp(input logic [27:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ {4'h0, a[27:24]} ^ 8'h3C;
  endfunction

  always @(negedge clk) begin
    logic a;
    a = mem_req && ($urandom % 3 != 0);
    mem_ack = a;
    mem_rdata = hp(mem_addr);
    if (a) begin
      hs++;
      if (mem_we) begin
        wlog_a[wn % 4096] = mem_addr;
        wlog_d[wn % 4096] = mem_wdata;
        wn++;
      end
    end
    if (irq_set != 0) begin
      irq_n++;
      irq_last = irq_set;
    end
  end

  task automatic wreg(input logic [7:0] off, input bit wide, input logic [63:0] d);
    reg_word = off[7:2]; reg_wide = wide; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [7:0] off, input bit wide, output logic [63:0] d);
    reg_word = off[7:2]; reg_wide = wide;
    #1 d = reg_rdata;
  endtask

  task automatic bread(input int i, output logic [7:0] d);
    buf_addr = 12'(i);
    #1 d = buf_rdata;
  endtask

  function automatic int eff_len(input logic [63:0] dev, input logic [63:0] cnt);
    logic [63:0] room;
    if (dev < 64'h40000 || dev - 64'h40000 >= 64'd4096) return 0;
    room = 64'd4096 - (dev - 64'h40000);
    return (cnt < room) ? int'(cnt) : int'(room);
  endfunction

  task automatic wait_idle();
    logic [63:0] v;
    for (int k = 0; k < 20000; k++) begin
      rreg(8'h98, 1'b1, v);
      if (!v[0]) break;
      @(negedge clk);
    end
    @(negedge clk); @(negedge clk);
  endtask

  task automatic xfer(input logic [63:0] src, input logic [63:0] dst, input logic [63:0] cnt,
                      input logic [2:0] cmd, input string tag);
    logic [63:0] v, dev, host;
    logic [7:0] b;
    int n, idx;
    bit dir;
    dir = cmd[1];
    dev = dir ? src : dst;
    host = dir ? dst : src;
    n = eff_len(dev, cnt);
    idx = int'(dev - 64'h40000);
    wreg(8'h80, 1'b1, src);
    wreg(8'h88, 1'b1, dst);
    wreg(8'h90, 1'b1, cnt);
    hs = 0; wn = 0; irq_n = 0; irq_last = 0;
    wreg(8'h98, 1'b1, {61'b0, cmd});
    rreg(8'h98, 1'b1, v);
    chk(v[0] == 1'b1, {"R3 start bit high ", tag}, v, 1);
    wait_idle();
    rreg(8'h98, 1'b1, v);
    chk(v[0] == 1'b0, {"R3 start bit low ", tag}, v, 0);
    chk(hs == n, {"R11/R7 handshakes ", tag}, 64'(hs), 64'(n));
    chk(irq_n == (cmd[2] ? 1 : 0) && (!cmd[2] || irq_last == 32'h100),
        {"R8 irq ", tag}, {32'(irq_n), irq_last}, cmd[2] ? 64'h1_00000100 : 0);
    if (!dir) begin
      for (int i = 0; i < n; i++) shadow[idx + i] = hp(28'(host + 64'(i)));
      for (int i = -2; i < n + 2; i++) begin
        if (n > 0 && idx + i >= 0 && idx + i < 4096) begin
          bread(idx + i, b);
          chk(b == shadow[idx + i], {"R4 buffer byte ", tag}, b, shadow[idx + i]);
        end
      end
    end else begin
      chk(wn == n, {"R5 write count ", tag}, 64'(wn), 64'(n));
      for (int i = 0; i < n && i < wn; i++) begin
        chk(wlog_a[i] == 28'(host + 64'(i)), {"R6 host address ", tag}, wlog_a[i], 28'(host + 64'(i)));
        chk(wlog_d[i] == shadow[idx + i], {"R5 written byte ", tag}, wlog_d[i], shadow[idx + i]);
      end
    end
  endtask

  initial begin
    logic [63:0] v;
    logic [7:0] b;
    bit same;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rreg(8'h98, 1'b1, v);
    chk(v == 0, "R1 command after reset", v, 0);
    chk(mem_req == 0 && irq_set == 0, "R1 outputs after reset", {mem_req, irq_set}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rreg(8'h98, 1'b1, v);
    chk(v == 0, "R1 command idle", v, 0);

    wreg(8'h80, 1'b1, 64'h1122334455667788);
    rreg(8'h80, 1'b1, v);
    chk(v == 64'h1122334455667788, "R2 wide write src", v, 64'h1122334455667788);
    wreg(8'h84, 1'b0, 64'hAABBCCDD);
    rreg(8'h80, 1'b1, v);
    chk(v == 64'hAABBCCDD55667788, "R2 narrow upper write", v, 64'hAABBCCDD55667788);
    rreg(8'h80, 1'b0, v);
    chk(v == 64'h55667788, "R2 narrow lower read", v, 64'h55667788);
    wreg(8'h90, 1'b0, 64'h1234);
    rreg(8'h94, 1'b0, v);
    chk(v == 0, "R2 count upper half", v, 0);

    for (int i = 0; i < 4096; i++) begin
      shadow[i] = 8'(i * 13 + 7);
      buf_addr = 12'(i); buf_wdata = shadow[i]; buf_we = 1'b1;
      @(negedge clk);
    end
    buf_we = 1'b0;

    xfer(64'h0000_0000_0001_2340, 64'h40010, 64'd20, 3'b101, "R4 dir0 irq");
    xfer(64'h40100, 64'h1234_0000_0FFF_FFFC, 64'd8, 3'b011, "R6 dir1 wrap");
    xfer(64'h40200, 64'h0000_0000_0000_5000, 64'd33, 3'b111, "R5 dir1 irq");
    xfer(64'h0ABC_DEF0, 64'h40000 + 64'd4090, 64'd20, 3'b001, "R7 clamp end");
    xfer(64'h0ABC_DEF0, 64'h40000 + 64'd4095, 64'h1_0000_0000, 3'b001, "R7 huge count");
    xfer(64'h0000_1000, 64'h3FFFF, 64'd10, 3'b101, "R7 below window");
    xfer(64'h41000, 64'h0000_2000, 64'd10, 3'b011, "R7 above window");
    same = 1;
    for (int i = 0; i < 4096; i++) begin
      bread(i, b);
      if (b != shadow[i]) same = 0;
    end
    chk(same, "R7 buffer untouched by out-of-window copies", 64'(same), 1);

    xfer(64'h0000_0100, 64'h40000, 64'd0, 3'b101, "R10 zero count");
    wreg(8'h90, 1'b1, 64'd0);
    wreg(8'h98, 1'b1, 64'h5);
    rreg(8'h98, 1'b1, v);
    chk(v[0] == 1, "R10 busy first cycle", v, 1);
    @(negedge clk);
    rreg(8'h98, 1'b1, v);
    chk(v[0] == 0, "R10 busy cleared after one cycle", v, 0);
    repeat (2) @(negedge clk);

    wreg(8'h80, 1'b1, 64'h0000_3000);
    wreg(8'h88, 1'b1, 64'h40800);
    wreg(8'h90, 1'b1, 64'd200);
    hs = 0;
    wreg(8'h98, 1'b1, 64'h1);
    wreg(8'h90, 1'b1, 64'd5);
    wreg(8'h80, 1'b1, 64'h0000_9999);
    wreg(8'h98, 1'b1, 64'h6);
    rreg(8'h90, 1'b1, v);
    chk(v == 200, "R9 count frozen while busy", v, 200);
    rreg(8'h80, 1'b1, v);
    chk(v == 64'h3000, "R9 source frozen while busy", v, 64'h3000);
    rreg(8'h98, 1'b1, v);
    chk(v[2:0] == 3'b001, "R9 command frozen while busy", v, 1);
    wait_idle();
    chk(hs == 200, "R9 full length moved", 64'(hs), 200);
    for (int i = 0; i < 200; i++) shadow[12'h800 + i] = hp(28'(64'h3000 + 64'(i)));
    bread(12'h800 + 199, b);
    chk(b == shadow[12'h800 + 199], "R9 last byte from original source", b, shadow[12'h800 + 199]);

    for (int k = 0; k < 14; k++) begin
      logic [63:0] host, dev, cnt;
      logic [2:0] cmd;
      cmd = {1'($urandom % 2), 1'($urandom % 2), 1'b1};
      host = {$urandom, $urandom};
      dev = ($urandom % 8 == 0) ? 64'h30000 + 64'($urandom % 65536) : 64'h40000 + 64'($urandom % 4200);
      cnt = 64'($urandom % 64);
      if (cmd[1]) xfer(dev, host, cnt, cmd, "R4/R5 random");
      else        xfer(host, dev, cnt, cmd, "R4/R5 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule